// File: doc/BRIEF.md
# Flash Chip-Select Segment Window Decoder

This block keeps one window register per flash chip-select of a serial-flash memory controller. Each window is a slice of a larger flash aperture, and its bounds are counted in 8 MB units. Software reprograms a window through a simple register port. Every write is checked in the same cycle. A write that would break the map is dropped, and the block latches a sticky error flag together with the index of the offending chip-select. A write that is legal but misaligned is kept, and it raises a sticky warning.

On the memory side, a byte address is decoded combinationally. The result is either a one-hot chip-select with the offset into that device, or a miss. At reset each window takes a default extent. The defaults are packed back to back from the aperture base, with sizes set by a parameter.

Top module: `segdec_top`

## Requirements
- R1: A window register reads back as {endUnit[31:24], startUnit[23:16], 16'h0}. A unit is 8 MB, and the end is exclusive. Reading an index at or above NUM_CS returns zero.
- R2: After reset the windows are contiguous from the aperture base. With the default parameters the reset values are CS0 = 0x5040_0000, CS1 = 0x5450_0000 and CS2 = 0x5854_0000.
- R3: A write to CS0 whose start field differs from the aperture base unit (0x40) is rejected.
- R4: When LOCK_LAST_END is 1 (the default), a write to the highest chip-select whose end field differs from its reset end (0x58) is rejected.
- R5: A write is rejected if its end is at or below the aperture base unit, if its start is above the aperture end unit (0x60), or if its end is not above its start.
- R6: A write is rejected if the new window overlaps the current window of any other chip-select. Overlap means newStart < otherEnd and newEnd > otherStart.
- R7: An accepted write whose start is not a multiple of its size is still stored, and it sets the sticky warnMisalign output.
- R8: A write whose data equals the current register value changes no register and no flag.
- R9: A rejected write leaves every register unchanged. It sets the sticky errFlag and loads errCs with the written index. A clrStatus pulse clears errFlag and warnMisalign. If a new error arrives in the same cycle as the clear, the error wins.
- R10: memAddr falls in a window when its unit (bits 31:23) is at least start and below end. In that case csHit is one-hot for that chip-select, csOffset = memAddr − start×8 MB and memMiss is 0. Otherwise csHit is 0 and memMiss is 1.
- R11: A write to an index at or above NUM_CS has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regIdx | input | IDX_W | Chip-select index written |
| regWrData | input | 32 | Write data |
| regRdIdx | input | IDX_W | Chip-select index read |
| regRdData | output | 32 | Read data (combinational) |
| clrStatus | input | 1 | Clears errFlag and warnMisalign |
| errFlag | output | 1 | Sticky rejected-write flag |
| errCs | output | IDX_W | Index of the last rejected write |
| warnMisalign | output | 1 | Sticky misalignment warning |
| memAddr | input | ADDR_W | Memory-side byte address |
| csHit | output | NUM_CS | One-hot chip-select hit |
| csOffset | output | ADDR_W | Offset inside the hit window |
| memMiss | output | 1 | No window contains memAddr |

## Verification
A wrongly stored or wrongly kept window shows up at the ports straight away, in two places. The combinational read port returns the wrong fields in the cycle after the write. The decode outputs move a probe address into the wrong chip-select, or report a false miss. A validation fault shows the same way, and errFlag and errCs also change one clock after the bad write. For that reason every register, flag and a probe decode are compared with a reference model after each write or clear.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
  // One window, both bounds in 8 MB units, end exclusive
  typedef struct packed {
    logic [7:0] endU;
    logic [7:0] startU;
  } segWin_t;

  // Strobes from validation control to the register datapath
  typedef struct packed {
    logic commit;
    logic reject;
    logic warn;
  } segStrobe_t;
endpackage

// File: rtl/segdec_ctrl.sv
module segdec_ctrl
  import segdec_pkg::*;
#(
  parameter int NUM_CS        = 3,
  parameter int IDX_W         = 2,
  parameter int BASE_U        = 64,
  parameter int AP_UNITS      = 32,
  parameter bit LOCK_LAST_END = 1'b1,
  parameter int LAST_END_U    = 88
) (
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [31:0]      wrData,
  input  segWin_t          segBank [NUM_CS],
  output segStrobe_t       strobe
);
  localparam int AP_END_U = BASE_U + AP_UNITS;

  logic [7:0] newStart, newEnd, newSize;
  logic       idxOk, sameVal, badLock, badRange, overlap;
  logic [31:0] curWord;

  assign newStart = wrData[23:16];
  assign newEnd   = wrData[31:24];
  assign newSize  = newEnd - newStart;
  assign idxOk    = 32'(wrIdx) < NUM_CS;

  always_comb begin
    curWord = '0;
    overlap = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (32'(wrIdx) == i) curWord = {segBank[i].endU, segBank[i].startU, 16'h0};
      else if (newStart < segBank[i].endU && newEnd > segBank[i].startU) overlap = 1'b1;
    end
  end

  assign sameVal  = (wrData == curWord);
  assign badLock  = (wrIdx == '0 && 32'(newStart) != BASE_U) ||
                    (LOCK_LAST_END && 32'(wrIdx) == NUM_CS - 1 && 32'(newEnd) != LAST_END_U);
  assign badRange = (newEnd <= newStart) || (32'(newEnd) <= BASE_U) ||
                    (32'(newStart) > AP_END_U);

  always_comb begin
    strobe = '0;
    if (wrEn && idxOk && !sameVal) begin
      if (badLock || badRange || overlap) strobe.reject = 1'b1;
      else begin
        strobe.commit = 1'b1;
        strobe.warn   = (newStart % newSize) != 8'd0;
      end
    end
  end
endmodule

// File: rtl/segdec_dp.sv
module segdec_dp
  import segdec_pkg::*;
#(
  parameter int NUM_CS     = 3,
  parameter int IDX_W      = 2,
  parameter int ADDR_W     = 32,
  parameter int UNIT_SHIFT = 23,
  parameter int BASE_U     = 64,
  parameter logic [NUM_CS*8-1:0] DEF_SIZES_U = {8'd4, 8'd4, 8'd16}
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [31:0]       wrData,
  input  logic              clrStatus,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [31:0]       rdData,
  output segWin_t           segBank [NUM_CS],
  output logic              errFlag,
  output logic [IDX_W-1:0]  errCs,
  output logic              warnMisalign,
  input  logic [ADDR_W-1:0] memAddr,
  output logic [NUM_CS-1:0] csHit,
  output logic [ADDR_W-1:0] csOffset,
  output logic              memMiss
);
  localparam int UNIT_W = ADDR_W - UNIT_SHIFT;

  function automatic logic [7:0] defStart(int cs);
    int acc = BASE_U;
    for (int k = 0; k < cs; k++) acc += int'(DEF_SIZES_U[k*8 +: 8]);
    return acc[7:0];
  endfunction

  logic [UNIT_W-1:0] addrUnit;
  assign addrUnit = memAddr[ADDR_W-1:UNIT_SHIFT];

  for (genvar g = 0; g < NUM_CS; g++) begin : gWin
    always_ff @(posedge clk) begin
      if (!rstN) begin
        segBank[g].startU <= defStart(g);
        segBank[g].endU   <= defStart(g) + DEF_SIZES_U[g*8 +: 8];
      end else if (strobe.commit && 32'(wrIdx) == g) begin
        segBank[g].startU <= wrData[23:16];
        segBank[g].endU   <= wrData[31:24];
      end
    end
    assign csHit[g] = (addrUnit >= UNIT_W'(segBank[g].startU)) &&
                      (addrUnit <  UNIT_W'(segBank[g].endU));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag      <= 1'b0;
      errCs        <= '0;
      warnMisalign <= 1'b0;
    end else begin
      if (clrStatus) begin
        errFlag      <= 1'b0;
        warnMisalign <= 1'b0;
      end
      if (strobe.reject) begin
        errFlag <= 1'b1;
        errCs   <= wrIdx;
      end
      if (strobe.warn) warnMisalign <= 1'b1;
    end
  end

  always_comb begin
    csOffset = '0;
    rdData   = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (csHit[i]) csOffset = memAddr - (ADDR_W'(segBank[i].startU) << UNIT_SHIFT);
      if (32'(rdIdx) == i) rdData = {segBank[i].endU, segBank[i].startU, 16'h0};
    end
  end

  assign memMiss = (csHit == '0);
endmodule

// File: rtl/segdec_top.sv
module segdec_top
  import segdec_pkg::*;
#(
  parameter int NUM_CS        = 3,
  parameter int IDX_W         = $clog2(NUM_CS + 1),
  parameter int ADDR_W        = 32,
  parameter int UNIT_SHIFT    = 23,
  parameter int BASE_U        = 64,
  parameter int AP_UNITS      = 32,
  parameter bit LOCK_LAST_END = 1'b1,
  parameter logic [NUM_CS*8-1:0] DEF_SIZES_U = {8'd4, 8'd4, 8'd16}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [31:0]       regWrData,
  input  logic [IDX_W-1:0]  regRdIdx,
  output logic [31:0]       regRdData,
  input  logic              clrStatus,
  output logic              errFlag,
  output logic [IDX_W-1:0]  errCs,
  output logic              warnMisalign,
  input  logic [ADDR_W-1:0] memAddr,
  output logic [NUM_CS-1:0] csHit,
  output logic [ADDR_W-1:0] csOffset,
  output logic              memMiss
);
  function automatic int lastEnd();
    int acc = BASE_U;
    for (int k = 0; k < NUM_CS; k++) acc += int'(DEF_SIZES_U[k*8 +: 8]);
    return acc;
  endfunction
  localparam int LAST_END_U = lastEnd();

  segWin_t    segBank [NUM_CS];
  segStrobe_t strobe;

  segdec_ctrl #(
    .NUM_CS(NUM_CS), .IDX_W(IDX_W), .BASE_U(BASE_U), .AP_UNITS(AP_UNITS),
    .LOCK_LAST_END(LOCK_LAST_END), .LAST_END_U(LAST_END_U)
  ) uCtrl (
    .wrEn(regWrEn), .wrIdx(regIdx), .wrData(regWrData),
    .segBank(segBank), .strobe(strobe)
  );

  segdec_dp #(
    .NUM_CS(NUM_CS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT),
    .BASE_U(BASE_U), .DEF_SIZES_U(DEF_SIZES_U)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(regIdx), .wrData(regWrData),
    .clrStatus(clrStatus), .rdIdx(regRdIdx), .rdData(regRdData),
    .segBank(segBank), .errFlag(errFlag), .errCs(errCs),
    .warnMisalign(warnMisalign), .memAddr(memAddr), .csHit(csHit),
    .csOffset(csOffset), .memMiss(memMiss)
  );
endmodule

// File: rtl/segdec_chk.sv
module segdec_chk
  import segdec_pkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int IDX_W  = 2,
  parameter int BASE_U = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [IDX_W-1:0]  regIdx,
  input logic [31:0]       regWrData,
  input segWin_t           segBank [NUM_CS],
  input segStrobe_t        strobe,
  input logic [NUM_CS-1:0] csHit,
  input logic              memMiss,
  input logic              errFlag,
  input logic              clrStatus
);
  logic [NUM_CS*16-1:0] bankFlat;
  logic                 overlapAny, sameVal;

  always_comb begin
    overlapAny = 1'b0;
    sameVal    = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      bankFlat[i*16 +: 16] = segBank[i];
      if (32'(regIdx) == i && regWrData == {segBank[i].endU, segBank[i].startU, 16'h0})
        sameVal = 1'b1;
      for (int j = i + 1; j < NUM_CS; j++)
        if (segBank[i].startU < segBank[j].endU && segBank[i].endU > segBank[j].startU)
          overlapAny = 1'b1;
    end
  end

  // R3: the CS0 start never leaves the aperture base
  a_r3_cs0_start_fixed: assert property (@(posedge clk) disable iff (!rstN)
    32'(segBank[0].startU) == BASE_U);
  // R6: windows held in the bank never overlap
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rstN) !overlapAny);
  // R8: a same-value write triggers neither commit nor reject
  a_r8_same_value_idle: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && sameVal) |-> !strobe.commit && !strobe.reject);
  // R9: a rejected write leaves the bank unchanged and raises errFlag
  a_r9_reject_stable: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && strobe.reject) |=> $stable(bankFlat) && errFlag);
  // R9: errFlag is sticky until cleared
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clrStatus) |=> errFlag);
  // R10: hit is one-hot and miss is its complement
  a_r10_onehot_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csHit) && (memMiss == (csHit == '0)));
endmodule

bind segdec_top segdec_chk #(.NUM_CS(NUM_CS), .IDX_W(IDX_W), .BASE_U(BASE_U)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx), .regWrData(regWrData),
  .segBank(segBank), .strobe(strobe), .csHit(csHit), .memMiss(memMiss),
  .errFlag(errFlag), .clrStatus(clrStatus)
);

// File: tb/tb_segdec_top.sv
`timescale 1ns/1ps
module tb_segdec_top;
  localparam int N = 3;
  localparam int IW = 2;

  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0, clrStatus = 1'b0;
  logic [IW-1:0] regIdx = '0, regRdIdx = '0, errCs;
  logic [31:0] regWrData = '0, regRdData, memAddr = '0, csOffset;
  logic errFlag, warnMisalign, memMiss;
  logic [N-1:0] csHit;

  int vectors = 0, fails = 0;
  bit done = 1'b0;
  int mS [N], mE [N];
  int mErr = 0, mErrCs = 0, mWarn = 0;

  always #4 clk = ~clk;

  segdec_top dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx), .regWrData(regWrData),
    .regRdIdx(regRdIdx), .regRdData(regRdData), .clrStatus(clrStatus),
    .errFlag(errFlag), .errCs(errCs), .warnMisalign(warnMisalign),
    .memAddr(memAddr), .csHit(csHit), .csOffset(csOffset), .memMiss(memMiss)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // R1 R2 R9: compare every register and flag with the model
  task automatic compareAll(string req);
    for (int i = 0; i <= N; i++) begin
      logic [31:0] exp;
      regRdIdx = IW'(i);
      #1;
      exp = (i < N) ? {mE[i][7:0], mS[i][7:0], 16'h0} : 32'h0;
      chk({req, " R1 read"}, regRdData, exp);
    end
    chk({req, " R9 errFlag"}, 32'(errFlag), 32'(mErr));
    chk({req, " R9 errCs"}, 32'(errCs), 32'(mErrCs));
    chk({req, " R7 warn"}, 32'(warnMisalign), 32'(mWarn));
  endtask

  // R10: decode check against the model windows
  task automatic probe(logic [31:0] a);
    int u, hitIdx;
    logic [31:0] expOff;
    memAddr = a;
    #1;
    u = int'(a >> 23);
    hitIdx = -1;
    expOff = 0;
    for (int i = 0; i < N; i++)
      if (u >= mS[i] && u < mE[i]) begin hitIdx = i; expOff = a - (32'(mS[i]) << 23); end
    chk("R10 csHit", 32'(csHit), (hitIdx < 0) ? 32'h0 : (32'h1 << hitIdx));
    chk("R10 memMiss", 32'(memMiss), 32'(hitIdx < 0));
    if (hitIdx >= 0) chk("R10 csOffset", csOffset, expOff);
  endtask

  function automatic void modelWrite(int idx, logic [31:0] d);
    int ns, ne;
    bit rej;
    if (idx >= N) return;                              // R11
    if (d == {mE[idx][7:0], mS[idx][7:0], 16'h0}) return; // R8
    ns = int'(d[23:16]);
    ne = int'(d[31:24]);
    rej = (idx == 0 && ns != 64) || (idx == N - 1 && ne != 88) ||
          ne <= ns || ne <= 64 || ns > 96;
    for (int i = 0; i < N; i++)
      if (i != idx && ns < mE[i] && ne > mS[i]) rej = 1'b1;
    if (rej) begin mErr = 1; mErrCs = idx; end
    else begin
      mS[idx] = ns; mE[idx] = ne;
      if (ns % (ne - ns) != 0) mWarn = 1;
    end
  endfunction

  task automatic wr(int idx, logic [31:0] d, string req);
    @(negedge clk);
    regWrEn = 1'b1; regIdx = IW'(idx); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    modelWrite(idx, d);
    compareAll(req);
  endtask

  task automatic clr();
    @(negedge clk);
    clrStatus = 1'b1;
    @(negedge clk);
    clrStatus = 1'b0;
    mErr = 0; mWarn = 0;
    compareAll("R9 clear");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    mS[0] = 64; mE[0] = 80; mS[1] = 80; mE[1] = 84; mS[2] = 84; mE[2] = 88;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R2 reset");
    probe(32'h2000_0010);
    probe(32'h2812_3456);
    probe(32'h2A00_0000);
    probe(32'h2C00_0000);
    probe(32'h1000_0000);
    wr(1, 32'h5450_0000, "R8 same value");
    wr(0, 32'h5041_0000, "R3 cs0 start");
    clr();
    wr(2, 32'h5A54_0000, "R4 last end");
    wr(0, 32'h4840_0000, "R5 shrink cs0");
    wr(1, 32'h3020_0000, "R5 below base");
    wr(1, 32'h7065_0000, "R5 above end");
    wr(1, 32'h5050_0000, "R5 empty");
    wr(1, 32'h4C46_0000, "R6 overlap");
    clr();
    wr(1, 32'h4E49_0000, "R7 misaligned");
    probe(32'h2480_0000);
    probe(32'h2400_0000);
    wr(1, 32'h5450_0000, "R7 aligned");
    clr();
    wr(3, 32'h1234_0000, "R11 bad index");
    probe(32'h2A10_0004);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule